// File: doc/BRIEF.md
# Page-fault checksum fetch sequencer

This block services one page fault at a time for a paged region kept in external memory, where each page is guarded by a 32-bit checksum. The checksums of the data pages are packed into checksum pages, and these checksum pages can be swapped out to external memory too. The checksum of each checksum page (the root checksum) is always kept inside the block, together with a residency bit per checksum page.

When a fault arrives, the sequencer finds which checksum page covers the target page. With the default parameters there are 4096 pages of 4 KB and four checksum pages of 1024 entries, so the checksum page index is the page number shifted right by 10. If that checksum page is resident, the sequencer reads the target's checksum from the internal table and fetches the target page. If it is not resident, the sequencer first fetches the checksum page, has it verified against its root checksum, marks it resident, and only then reads the target's checksum and fetches the target page. The sequencer gives every verification the expected checksum. A failed verification stops the block in a halt state until reset.

Victim selection drives the eviction port, which records a checksum page as swapped out together with its root checksum. The external memory drives the fetch port and the integrity checker drives the check port.

Top module: `csum_fault_seq`

## Requirements
- R1: After reset, req_ready_o is 1, halt_o, done_o, fetch_valid_o, chk_valid_o and tbl_rd_en_o are 0, and all checksum pages count as resident, so no checksum-page fetch happens until an eviction.
- R2: req_ready_o is 1 only while the sequencer is idle. A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. A request presented while busy is ignored and never fetched.
- R3: When the covering checksum page is resident, tbl_rd_en_o is 1 for exactly one cycle, starting one cycle after acceptance (or one cycle after a checksum page passes), with tbl_rd_addr_o equal to the faulting page number. The target fetch starts in the next cycle.
- R4: When the covering checksum page is not resident, the first fetch has fetch_is_csum_o=1 and fetch_page_o equal to the checksum page index (page number bits 11:10, zero-extended). A fetch request holds until fetch_done_i.
- R5: A checksum page is verified with chk_expect_o equal to the root checksum recorded at its eviction. The target page is fetched only after that verification passes.
- R6: A checksum page that passes verification is marked resident, so a later fault covered by it needs no checksum-page fetch.
- R7: The target page is verified with chk_expect_o equal to the table word returned on tbl_rd_data_i in the cycle after the table read.
- R8: A verification with chk_pass_i=0 puts the block in a halt state: halt_o=1, req_ready_o=0, and no fetch, check or table read until reset.
- R9: done_o is 1 for exactly one cycle, in the cycle after the target page passes. The block is idle in the cycle after that.
- R10: An eviction (evict_valid_i) takes effect only while the block is idle. It marks checksum page evict_idx_i non-resident and stores evict_csum_i as its root checksum. An eviction presented while busy is ignored.
- R11: fetch_done_i outside a fetch and chk_done_i outside a verification have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Page fault request |
| req_page_i | input | 12 | Faulting page number |
| req_ready_o | output | 1 | Idle, request can be taken |
| evict_valid_i | input | 1 | Checksum page swapped out |
| evict_idx_i | input | 2 | Index of swapped-out checksum page |
| evict_csum_i | input | 32 | Root checksum of that checksum page |
| tbl_rd_en_o | output | 1 | Checksum table read strobe |
| tbl_rd_addr_o | output | 12 | Table read address (page number) |
| tbl_rd_data_i | input | 32 | Table word, valid one cycle after the strobe |
| fetch_valid_o | output | 1 | Page fetch request |
| fetch_is_csum_o | output | 1 | Fetch targets a checksum page |
| fetch_page_o | output | 12 | Page number or checksum page index |
| fetch_done_i | input | 1 | Fetched page is in internal memory |
| chk_valid_o | output | 1 | Verification request |
| chk_expect_o | output | 32 | Expected checksum for the fetched page |
| chk_done_i | input | 1 | Checker result is valid |
| chk_pass_i | input | 1 | Checker result: page matches |
| done_o | output | 1 | Fault serviced (one-cycle pulse) |
| halt_o | output | 1 | Verification failed, block halted |

## Verification
The assertions check on every cycle that:
- a checksum-page fetch happens only for a non-resident page;
- a target fetch happens only once the covering checksum page is resident;
- a fetch holds its page number until it completes;
- a table read is a single cycle followed by a target fetch;
- done follows a passing check;
- halt is sticky and quiet;
- eviction and verification updates of the residency table are visible one cycle later.

Only the bench scenarios can show the rest. These are the ordering of the two fetches within one fault, the exact expected checksum values, that requests and evictions made while busy leave no trace, that stray completion pulses are ignored, and that reset restores residency.

// File: rtl/csum_seq_pkg.sv
package csum_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FETCH_CS,
    ST_VERIFY_CS,
    ST_FETCH_TGT,
    ST_VERIFY_TGT,
    ST_DONE,
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/csum_root_table.sv
module csum_root_table #(
  parameter int IDX_W  = 2,
  parameter int CSUM_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [CSUM_W-1:0] clr_csum_i,
  input  logic              set_en_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              resident_o,
  output logic [CSUM_W-1:0] root_o
);
  localparam int N_CS = 1 << IDX_W;

  logic [N_CS-1:0]   res_vec;
  logic [CSUM_W-1:0] root_arr [N_CS];

  for (genvar g = 0; g < N_CS; g++) begin : g_ent
    logic              res_r;
    logic [CSUM_W-1:0] root_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_r  <= 1'b1;
        root_r <= '0;
      end else if (clr_en_i && clr_idx_i == IDX_W'(g)) begin
        res_r  <= 1'b0;
        root_r <= clr_csum_i;
      end else if (set_en_i && set_idx_i == IDX_W'(g)) begin
        res_r  <= 1'b1;
      end
    end
    assign res_vec[g]  = res_r;
    assign root_arr[g] = root_r;
  end

  assign resident_o = res_vec[rd_idx_i];
  assign root_o     = root_arr[rd_idx_i];

  a_r10_no_set_clr_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_en_i && clr_en_i));
  a_r10_evict_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !res_vec[$past(clr_idx_i)] && root_arr[$past(clr_idx_i)] == $past(clr_csum_i));
  a_r6_set_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> res_vec[$past(set_idx_i)]);
endmodule

// File: rtl/csum_seq_fsm.sv
module csum_seq_fsm
  import csum_seq_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 2,
  parameter int CSUM_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              req_ready_o,
  input  logic              resident_i,
  input  logic [CSUM_W-1:0] root_csum_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              set_en_o,
  output logic              idle_o,
  output logic              tbl_rd_en_o,
  output logic [PAGE_W-1:0] tbl_rd_addr_o,
  input  logic [CSUM_W-1:0] tbl_rd_data_i,
  output logic              fetch_valid_o,
  output logic              fetch_is_csum_o,
  output logic [PAGE_W-1:0] fetch_page_o,
  input  logic              fetch_done_i,
  output logic              chk_valid_o,
  output logic [CSUM_W-1:0] chk_expect_o,
  input  logic              chk_done_i,
  input  logic              chk_pass_i,
  output logic              done_o,
  output logic              halt_o
);
  localparam int PAD_W = PAGE_W - IDX_W;

  seq_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [CSUM_W-1:0] tgt_csum_q;
  logic              rd_pend_q;

  assign idx_o = page_q[PAGE_W-1 -: IDX_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid_i) state_d = ST_LOOKUP;
      ST_LOOKUP:     state_d = resident_i ? ST_FETCH_TGT : ST_FETCH_CS;
      ST_FETCH_CS:   if (fetch_done_i) state_d = ST_VERIFY_CS;
      ST_VERIFY_CS:  if (chk_done_i) state_d = chk_pass_i ? ST_LOOKUP : ST_HALT;
      ST_FETCH_TGT:  if (fetch_done_i) state_d = ST_VERIFY_TGT;
      ST_VERIFY_TGT: if (chk_done_i) state_d = chk_pass_i ? ST_DONE : ST_HALT;
      ST_DONE:       state_d = ST_IDLE;
      ST_HALT:       state_d = ST_HALT;
      default:       state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      tgt_csum_q <= '0;
      rd_pend_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_pend_q <= tbl_rd_en_o;
      if (state_q == ST_IDLE && req_valid_i) page_q <= req_page_i;
      if (rd_pend_q) tgt_csum_q <= tbl_rd_data_i;
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign idle_o          = (state_q == ST_IDLE);
  assign tbl_rd_en_o     = (state_q == ST_LOOKUP) && resident_i;
  assign tbl_rd_addr_o   = page_q;
  assign fetch_valid_o   = (state_q == ST_FETCH_CS) || (state_q == ST_FETCH_TGT);
  assign fetch_is_csum_o = (state_q == ST_FETCH_CS);
  assign fetch_page_o    = fetch_is_csum_o ? {{PAD_W{1'b0}}, idx_o} : page_q;
  assign chk_valid_o     = (state_q == ST_VERIFY_CS) || (state_q == ST_VERIFY_TGT);
  assign chk_expect_o    = (state_q == ST_VERIFY_CS) ? root_csum_i : tgt_csum_q;
  assign set_en_o        = (state_q == ST_VERIFY_CS) && chk_done_i && chk_pass_i;
  assign done_o          = (state_q == ST_DONE);
  assign halt_o          = (state_q == ST_HALT);

  a_r2_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !fetch_valid_o && !chk_valid_o && !tbl_rd_en_o);
  a_r3_read_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_rd_en_o |=> !tbl_rd_en_o && fetch_valid_o && !fetch_is_csum_o);
  a_r4_csum_fetch_nonres: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && fetch_is_csum_o) |-> !resident_i);
  a_r4_fetch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !fetch_done_i) |=> fetch_valid_o && $stable(fetch_page_o));
  a_r5_target_after_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !fetch_is_csum_o) |-> resident_i);
  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !req_ready_o && !fetch_valid_o && !chk_valid_o && !tbl_rd_en_o);
  a_r9_done_after_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(chk_valid_o && chk_done_i && chk_pass_i && !fetch_is_csum_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
endmodule

// File: rtl/csum_fault_seq.sv
module csum_fault_seq #(
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 2,
  parameter int CSUM_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              req_ready_o,
  input  logic              evict_valid_i,
  input  logic [IDX_W-1:0]  evict_idx_i,
  input  logic [CSUM_W-1:0] evict_csum_i,
  output logic              tbl_rd_en_o,
  output logic [PAGE_W-1:0] tbl_rd_addr_o,
  input  logic [CSUM_W-1:0] tbl_rd_data_i,
  output logic              fetch_valid_o,
  output logic              fetch_is_csum_o,
  output logic [PAGE_W-1:0] fetch_page_o,
  input  logic              fetch_done_i,
  output logic              chk_valid_o,
  output logic [CSUM_W-1:0] chk_expect_o,
  input  logic              chk_done_i,
  input  logic              chk_pass_i,
  output logic              done_o,
  output logic              halt_o
);
  logic              resident;
  logic [CSUM_W-1:0] root_csum;
  logic [IDX_W-1:0]  idx;
  logic              set_en;
  logic              idle;
  logic              clr_en;

  // evictions only land while no fault is in flight
  assign clr_en = evict_valid_i && idle;

  csum_root_table #(.IDX_W(IDX_W), .CSUM_W(CSUM_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (clr_en),
    .clr_idx_i  (evict_idx_i),
    .clr_csum_i (evict_csum_i),
    .set_en_i   (set_en),
    .set_idx_i  (idx),
    .rd_idx_i   (idx),
    .resident_o (resident),
    .root_o     (root_csum)
  );

  csum_seq_fsm #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .CSUM_W(CSUM_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_page_i      (req_page_i),
    .req_ready_o     (req_ready_o),
    .resident_i      (resident),
    .root_csum_i     (root_csum),
    .idx_o           (idx),
    .set_en_o        (set_en),
    .idle_o          (idle),
    .tbl_rd_en_o     (tbl_rd_en_o),
    .tbl_rd_addr_o   (tbl_rd_addr_o),
    .tbl_rd_data_i   (tbl_rd_data_i),
    .fetch_valid_o   (fetch_valid_o),
    .fetch_is_csum_o (fetch_is_csum_o),
    .fetch_page_o    (fetch_page_o),
    .fetch_done_i    (fetch_done_i),
    .chk_valid_o     (chk_valid_o),
    .chk_expect_o    (chk_expect_o),
    .chk_done_i      (chk_done_i),
    .chk_pass_i      (chk_pass_i),
    .done_o          (done_o),
    .halt_o          (halt_o)
  );
endmodule

// File: tb/csum_fault_seq_test.sv
module csum_fault_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [11:0] req_page_i = '0;
  logic        req_ready_o;
  logic        evict_valid_i = 1'b0;
  logic [1:0]  evict_idx_i = '0;
  logic [31:0] evict_csum_i = '0;
  logic        tbl_rd_en_o;
  logic [11:0] tbl_rd_addr_o;
  logic [31:0] tbl_rd_data_i = '0;
  logic        fetch_valid_o, fetch_is_csum_o;
  logic [11:0] fetch_page_o;
  logic        fetch_done_i = 1'b0;
  logic        chk_valid_o;
  logic [31:0] chk_expect_o;
  logic        chk_done_i = 1'b0, chk_pass_i = 1'b0;
  logic        done_o, halt_o;

  always #10 clk = ~clk; // 50 MHz

  csum_fault_seq uut (.clk_i(clk), .*);

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tbl_val(input logic [11:0] a);
    return {a, 20'h0} ^ 32'hC3A5_0F1E ^ {20'h0, a} ^ {8'h0, a, 12'h0};
  endfunction

  // internal checksum table model
  always @(posedge clk) tbl_rd_data_i <= tbl_val(tbl_rd_addr_o);

  // responders
  bit fail_cs = 0, fail_tgt = 0, stray = 0, last_cs = 0;
  int fcnt = 0, ccnt = 0;
  always @(posedge clk) begin
    #2;
    fetch_done_i = stray;
    chk_done_i   = stray;
    chk_pass_i   = 1'b0;
    if (fetch_valid_o) begin
      last_cs = fetch_is_csum_o;
      fcnt++;
      if (fcnt >= 3) begin fetch_done_i = 1'b1; fcnt = 0; end
    end else fcnt = 0;
    if (chk_valid_o) begin
      ccnt++;
      if (ccnt >= 2) begin
        chk_done_i = 1'b1;
        chk_pass_i = last_cs ? !fail_cs : !fail_tgt;
        ccnt = 0;
      end
    end else ccnt = 0;
  end

  // behavioural reference: 0 idle,1 lookup,2 cs fetch,3 cs check,4 tgt fetch,5 tgt check,6 done,7 halt
  int          m_ph;
  logic [11:0] m_page;
  logic [3:0]  m_res;
  logic [31:0] m_root [4];
  logic [31:0] m_tgt;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_page = '0; m_res = 4'hF; m_tgt = '0;
      for (int i = 0; i < 4; i++) m_root[i] = '0;
    end else begin
      case (m_ph)
        0: begin
          if (evict_valid_i) begin m_res[evict_idx_i] = 1'b0; m_root[evict_idx_i] = evict_csum_i; end
          if (req_valid_i) begin m_page = req_page_i; m_ph = 1; end
        end
        1: if (m_res[m_page[11:10]]) begin m_ph = 4; m_tgt = tbl_val(m_page); end else m_ph = 2;
        2: if (fetch_done_i) m_ph = 3;
        3: if (chk_done_i) begin
             if (chk_pass_i) begin m_res[m_page[11:10]] = 1'b1; m_ph = 1; end else m_ph = 7;
           end
        4: if (fetch_done_i) m_ph = 5;
        5: if (chk_done_i) m_ph = chk_pass_i ? 6 : 7;
        6: m_ph = 0;
        default: m_ph = 7;
      endcase
    end
  end

  // fetch log
  int          n_log = 0, n_cs = 0;
  bit          log_cs [16];
  logic [11:0] log_pg [16];
  bit          prev_fv = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(req_ready_o == (m_ph == 0), "R2 ready", 32'(req_ready_o), 32'(m_ph == 0));
      chk(tbl_rd_en_o == (m_ph == 1 && m_res[m_page[11:10]]), "R3 table read", 32'(tbl_rd_en_o), 32'(m_ph == 1));
      if (tbl_rd_en_o) chk(tbl_rd_addr_o == m_page, "R3 table addr", 32'(tbl_rd_addr_o), 32'(m_page));
      chk(fetch_valid_o == (m_ph == 2 || m_ph == 4), "R4 fetch valid", 32'(fetch_valid_o), 32'(m_ph));
      if (fetch_valid_o) begin
        chk(fetch_is_csum_o == (m_ph == 2), "R4 fetch kind", 32'(fetch_is_csum_o), 32'(m_ph == 2));
        chk(fetch_page_o == ((m_ph == 2) ? {10'h0, m_page[11:10]} : m_page), "R4 fetch page",
            32'(fetch_page_o), 32'(m_page));
      end
      chk(chk_valid_o == (m_ph == 3 || m_ph == 5), "R5 check valid", 32'(chk_valid_o), 32'(m_ph));
      if (m_ph == 3) chk(chk_expect_o == m_root[m_page[11:10]], "R5 root expect", chk_expect_o, m_root[m_page[11:10]]);
      if (m_ph == 5) chk(chk_expect_o == m_tgt, "R7 target expect", chk_expect_o, m_tgt);
      chk(done_o == (m_ph == 6), "R9 done", 32'(done_o), 32'(m_ph == 6));
      chk(halt_o == (m_ph == 7), "R8 halt", 32'(halt_o), 32'(m_ph == 7));
      if (fetch_valid_o && !prev_fv && n_log < 16) begin
        log_cs[n_log] = fetch_is_csum_o;
        log_pg[n_log] = fetch_page_o;
        n_log++;
        if (fetch_is_csum_o) n_cs++;
      end
    end
    prev_fv = fetch_valid_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog R9 act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0; req_valid_i = 0; evict_valid_i = 0; fail_cs = 0; fail_tgt = 0; stray = 0;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
  endtask

  task automatic wait_end();
    while (!done_o && !halt_o) begin @(posedge clk); #2; end
    @(posedge clk); #2;
  endtask

  task automatic do_fault(input logic [11:0] p);
    @(posedge clk); #2; req_valid_i = 1; req_page_i = p;
    @(posedge clk); #2; req_valid_i = 0;
    wait_end();
  endtask

  task automatic do_evict(input logic [1:0] ix, input logic [31:0] c);
    @(posedge clk); #2; evict_valid_i = 1; evict_idx_i = ix; evict_csum_i = c;
    @(posedge clk); #2; evict_valid_i = 0;
  endtask

  initial begin
    int cs0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(req_ready_o && !halt_o && !done_o, "R1 reset ready", 32'({req_ready_o, halt_o, done_o}), 32'h4);
    chk(!fetch_valid_o && !chk_valid_o && !tbl_rd_en_o, "R1 reset quiet", 32'(fetch_valid_o), 0);

    // R1/R3: all resident after reset, four checksum pages
    n_log = 0; n_cs = 0;
    do_fault(12'h005); do_fault(12'h7FF); do_fault(12'h800); do_fault(12'hC00);
    chk(n_cs == 0, "R1 no csum fetch after reset", n_cs, 0);
    chk(n_log == 4, "R3 one target fetch each", n_log, 4);

    // R4/R5 non-resident path ordering
    do_evict(2'd2, 32'hDEAD_0002);
    n_log = 0; n_cs = 0;
    do_fault(12'h8A3);
    chk(n_log == 2, "R4 two fetches", n_log, 2);
    chk(log_cs[0] && log_pg[0] == 12'h002, "R4 csum page first", 32'(log_pg[0]), 32'h2);
    chk(!log_cs[1] && log_pg[1] == 12'h8A3, "R5 target after csum page", 32'(log_pg[1]), 32'h8A3);

    // R6 now resident
    n_log = 0; n_cs = 0;
    do_fault(12'h9FF);
    chk(n_cs == 0 && n_log == 1, "R6 resident after verify", n_cs, 0);

    // R2/R10 request and eviction while busy are ignored
    n_log = 0; n_cs = 0;
    @(posedge clk); #2; req_valid_i = 1; req_page_i = 12'h123;
    @(posedge clk); #2; req_valid_i = 0;
    @(posedge clk); #2; req_valid_i = 1; req_page_i = 12'hFFF; evict_valid_i = 1; evict_idx_i = 2'd0; evict_csum_i = 32'h1111_0000;
    @(posedge clk); #2; req_valid_i = 0; evict_valid_i = 0;
    wait_end();
    repeat (3) @(posedge clk);
    chk(n_log == 1 && log_pg[0] == 12'h123, "R2 busy request ignored", 32'(n_log), 1);
    n_log = 0; n_cs = 0;
    do_fault(12'h010);
    chk(n_cs == 0, "R10 busy eviction ignored", n_cs, 0);

    // R10 idle eviction applied, second eviction overwrites root
    do_evict(2'd1, 32'h0000_AAAA);
    do_evict(2'd1, 32'h5A5A_0001);
    n_log = 0; n_cs = 0;
    do_fault(12'h4C4);
    chk(n_cs == 1 && log_pg[0] == 12'h001, "R10 idle eviction applied", n_cs, 1);

    // R11 stray completions in idle
    @(posedge clk); #2; stray = 1;
    @(posedge clk); #2;
    @(posedge clk); #2; stray = 0;
    @(negedge clk);
    chk(req_ready_o && !fetch_valid_o && !chk_valid_o, "R11 stray pulses ignored", 32'(req_ready_o), 1);

    // R8 checksum page fails
    do_evict(2'd3, 32'hC0FF_EE03);
    fail_cs = 1;
    n_log = 0;
    do_fault(12'hC44);
    cs0 = n_log;
    @(posedge clk); #2; req_valid_i = 1; req_page_i = 12'h001;
    repeat (5) @(posedge clk);
    #2 req_valid_i = 0;
    @(negedge clk);
    chk(halt_o && !req_ready_o, "R8 halt holds", 32'(halt_o), 1);
    chk(n_log == cs0 && n_log == 1, "R8 no fetch after halt", n_log, 1);

    // reset restores residency (R1), then target fails (R8)
    do_reset();
    n_log = 0; n_cs = 0;
    do_fault(12'hC44);
    chk(n_cs == 0, "R1 residency restored by reset", n_cs, 0);
    fail_tgt = 1;
    do_fault(12'h222);
    @(negedge clk);
    chk(halt_o && !done_o, "R8 target failure halts", 32'(halt_o), 1);

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule